// File: doc/BRIEF.md
# Extended-Dividend Saturating Divider

This unit performs an iterative integer division for a 64-bit datapath. The dividend is 64 bits wide: its upper half comes from a separate 32-bit high-word input and its lower half from bits 31:0 of the first source operand. The divisor is 32 bits wide. The unit divides either as unsigned or as two's-complement signed numbers. When the quotient does not fit in 32 bits it is clamped to the nearest representable 32-bit value instead of wrapping, and the clamp limits differ between the two modes.

A request is issued by pulsing `start_i` while the unit is not busy. One quotient bit is produced per clock by a restoring shift-subtract loop. `busy_o` stays high for the 64 iteration cycles and is followed by a one-cycle `done_o` strobe that carries the 64-bit destination value. A zero divisor never enters the loop. It produces a one-cycle fault strobe instead, and no destination write takes place. When the condition-code variant is requested, the unit also reports negative, zero, overflow and carry flags along with the result.

Top module: `xdiv_unit`

## Requirements
- R1: In unsigned mode (`sgn_i`=0) the dividend is `{hi_word_i, src1_i[31:0]}` and the divisor is `divisor_i`. When the quotient fits in 32 bits, `result_o` carries it zero-extended to 64 bits while `done_o` is high.
- R2: In signed mode (`sgn_i`=1) the dividend and divisor are two's-complement values. The quotient truncates toward zero and, when it lies in [-2^31, 2^31-1], it is returned sign-extended to 64 bits.
- R3: A start with `divisor_i`==0 raises `dz_fault_o` for exactly the next cycle. `busy_o` and `done_o` stay low, so no destination value is delivered.
- R4: In unsigned mode, a quotient with any nonzero bit in 63:32 yields `result_o` = 0x00000000FFFFFFFF.
- R5: In signed mode, a positive quotient above 2^31-1 yields 0x000000007FFFFFFF. This includes -2^63 divided by -1.
- R6: In signed mode, a negative quotient below -2^31 yields 0xFFFFFFFF80000000. A quotient of exactly -2^31 is not clamped.
- R7: `icc_o` is {N,Z,V,C} at bits 3..0. With `cc_en_i`=1 at start, the strobe carries N=result[31], Z=(result[31:0]==0), V=1 exactly when clamping happened, and C=0. With `cc_en_i`=0, and whenever `done_o` is low, `icc_o` is 0.
- R8: After an accepted start with a nonzero divisor, `busy_o` is high for exactly 64 cycles. `done_o` is then high for one cycle while `busy_o` is low.
- R9: A start while `busy_o` is high is ignored: the running divide completes on time with the operands captured at its own start.
- R10: After reset, `busy_o`, `done_o` and `dz_fault_o` are low, and `result_o` and `icc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a divide (accepted when not busy) |
| sgn_i | input | 1 | 1 = signed divide, 0 = unsigned |
| cc_en_i | input | 1 | 1 = report condition flags with the result |
| hi_word_i | input | 32 | Upper half of the dividend |
| src1_i | input | 64 | First operand; bits 31:0 form the lower half of the dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 64 | Destination value, valid with done_o, else 0 |
| dz_fault_o | output | 1 | One-cycle divide-by-zero fault strobe |
| icc_o | output | 4 | {N,Z,V,C} flags, valid with done_o |

## Verification
Most internal faults show up at the ports as a wrong value on the single `done_o` strobe, 65 cycles after the start. A corrupted remainder or a wrong quotient bit changes the delivered value. A lost sign flag shows up as a wrongly signed or wrongly clamped result. Saturation is checked directly against the quotient limits, including the exact -2^31 and 2^31-1 boundaries. A counter or state error moves the strobe off the 64-cycle mark or makes it last more than one cycle, and the bench measures this on every operation. A wrongly accepted overlapping start reveals itself as a result computed from the intruding operands.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;
  typedef enum logic [1:0] {
    XD_IDLE  = 2'd0,
    XD_RUN   = 2'd1,
    XD_DONE  = 2'd2,
    XD_FAULT = 2'd3
  } xdiv_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } xdiv_icc_t;
endpackage

// File: rtl/xdiv_prep.sv
module xdiv_prep #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   dvs_i,
  input  logic            sgn_i,
  output logic [2*DW-1:0] dvd_mag_o,
  output logic [DW-1:0]   dvs_mag_o,
  output logic            q_neg_o,
  output logic            dvs_zero_o
);
  localparam int LW = 2 * DW;

  logic [LW-1:0] dvd;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    dvd        = {hi_i, lo_i};
    dvd_neg    = sgn_i & dvd[LW-1];
    dvs_neg    = sgn_i & dvs_i[DW-1];
    dvd_mag_o  = dvd_neg ? (~dvd + 1'b1) : dvd;
    dvs_mag_o  = dvs_neg ? (~dvs_i + 1'b1) : dvs_i;
    q_neg_o    = dvd_neg ^ dvs_neg;
    dvs_zero_o = (dvs_i == '0);
  end
endmodule

// File: rtl/xdiv_core.sv
module xdiv_core #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [2*DW-1:0] dvd_i,
  input  logic [DW-1:0]   dvs_i,
  output logic [2*DW-1:0] quo_o,
  output logic            last_o
);
  localparam int LW = 2 * DW;
  localparam int CW = $clog2(LW + 1);

  logic [DW:0]   rem_q, rem_d;
  logic [LW-1:0] shr_q, shr_d;
  logic [DW-1:0] dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW:0]   trial;
  logic          ge;
  logic          en;

  always_comb begin
    trial = {rem_q[DW-1:0], shr_q[LW-1]};
    ge    = (trial >= {1'b0, dvs_q});
    en    = load_i | (cnt_q != '0);
    rem_d = rem_q;
    shr_d = shr_q;
    dvs_d = dvs_q;
    cnt_d = cnt_q;
    if (load_i) begin
      rem_d = '0;
      shr_d = dvd_i;
      dvs_d = dvs_i;
      cnt_d = CW'(LW);
    end else if (cnt_q != '0) begin
      rem_d = ge ? (trial - {1'b0, dvs_q}) : trial;
      shr_d = {shr_q[LW-2:0], ge};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      shr_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      shr_q <= shr_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
    end
  end

  assign quo_o  = shr_q;
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/xdiv_post.sv
module xdiv_post
  import xdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2*DW-1:0] quo_mag_i,
  input  logic            q_neg_i,
  input  logic            sgn_i,
  output logic [2*DW-1:0] res_o,
  output xdiv_icc_t       icc_o
);
  localparam int LW = 2 * DW;
  localparam logic [LW-1:0] U_MAX = {{DW{1'b0}}, {DW{1'b1}}};
  localparam logic [LW-1:0] S_MAX = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [LW-1:0] S_MIN = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic          u_over;
  logic          p_over;
  logic          n_over;
  logic          sat;
  logic [LW-1:0] signed_val;

  always_comb begin
    u_over     = |quo_mag_i[LW-1:DW];
    p_over     = |quo_mag_i[LW-1:DW-1];
    n_over     = u_over | (quo_mag_i[DW-1] & (|quo_mag_i[DW-2:0]));
    signed_val = q_neg_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    if (!sgn_i) begin
      sat   = u_over;
      res_o = u_over ? U_MAX : quo_mag_i;
    end else if (q_neg_i) begin
      sat   = n_over;
      res_o = n_over ? S_MIN : signed_val;
    end else begin
      sat   = p_over;
      res_o = p_over ? S_MAX : signed_val;
    end
    icc_o.n = res_o[DW-1];
    icc_o.z = (res_o[DW-1:0] == '0);
    icc_o.v = sat;
    icc_o.c = 1'b0;
  end
endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit
  import xdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            sgn_i,
  input  logic            cc_en_i,
  input  logic [DW-1:0]   hi_word_i,
  input  logic [2*DW-1:0] src1_i,
  input  logic [DW-1:0]   divisor_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] result_o,
  output logic            dz_fault_o,
  output logic [3:0]      icc_o
);
  localparam int LW = 2 * DW;

  xdiv_state_e   state_q, state_d;
  logic          sgn_q, cc_q, neg_q;
  logic          accept, load;
  logic [LW-1:0] dvd_mag;
  logic [DW-1:0] dvs_mag;
  logic          q_neg, dvs_zero;
  logic [LW-1:0] quo;
  logic          last;
  logic [LW-1:0] post_res;
  xdiv_icc_t     post_icc;

  xdiv_prep #(.DW(DW)) u_prep (
    .hi_i       (hi_word_i),
    .lo_i       (src1_i[DW-1:0]),
    .dvs_i      (divisor_i),
    .sgn_i      (sgn_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .q_neg_o    (q_neg),
    .dvs_zero_o (dvs_zero)
  );

  xdiv_core #(.DW(DW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .quo_o  (quo),
    .last_o (last)
  );

  xdiv_post #(.DW(DW)) u_post (
    .quo_mag_i (quo),
    .q_neg_i   (neg_q),
    .sgn_i     (sgn_q),
    .res_o     (post_res),
    .icc_o     (post_icc)
  );

  always_comb begin
    accept  = start_i & (state_q != XD_RUN);
    load    = accept & ~dvs_zero;
    state_d = state_q;
    case (state_q)
      XD_RUN:  if (last) state_d = XD_DONE;
      default: state_d = XD_IDLE;
    endcase
    if (accept) state_d = dvs_zero ? XD_FAULT : XD_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q <= 1'b0;
      cc_q  <= 1'b0;
      neg_q <= 1'b0;
    end else if (load) begin
      sgn_q <= sgn_i;
      cc_q  <= cc_en_i;
      neg_q <= q_neg;
    end
  end

  always_comb begin
    busy_o     = (state_q == XD_RUN);
    done_o     = (state_q == XD_DONE);
    dz_fault_o = (state_q == XD_FAULT);
    result_o   = done_o ? post_res : '0;
    icc_o      = (done_o && cc_q) ? post_icc : 4'b0000;
  end
endmodule

// File: rtl/xdiv_unit_chk.sv
module xdiv_unit_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [DW-1:0]   divisor_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [2*DW-1:0] result_o,
  input logic            dz_fault_o,
  input logic [3:0]      icc_o
);
  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));
  // R8
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && divisor_i != '0) |=> busy_o);
  // R3
  dz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dz_fault_o |-> (!busy_o && !done_o));
  // R3
  dz_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dz_fault_o |-> ($past(start_i) && $past(divisor_i) == '0 && !$past(busy_o)));
  // R3
  dz_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && divisor_i == '0) |=> (dz_fault_o && !busy_o));
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
  // R7
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !icc_o[0]);
  // R7
  icc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (icc_o == 4'b0000));
  // R10
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (result_o == '0));
endmodule

bind xdiv_unit xdiv_unit_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .dz_fault_o (dz_fault_o),
  .icc_o      (icc_o)
);

// File: tb/tb_xdiv_unit.sv
module tb_xdiv_unit;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        sgn_i;
  logic        cc_en_i;
  logic [31:0] hi_word_i;
  logic [63:0] src1_i;
  logic [31:0] divisor_i;
  logic        busy_o;
  logic        done_o;
  logic [63:0] result_o;
  logic        dz_fault_o;
  logic [3:0]  icc_o;

  int checks   = 0;
  int failures = 0;

  xdiv_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sgn_i(sgn_i),
    .cc_en_i(cc_en_i), .hi_word_i(hi_word_i), .src1_i(src1_i),
    .divisor_i(divisor_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .dz_fault_o(dz_fault_o), .icc_o(icc_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_div(input logic [31:0] hi, input logic [63:0] s1,
                                          input logic [31:0] d, input bit sg, output bit sat);
    logic [63:0] dvd, am, q;
    logic [31:0] bm;
    bit neg;
    dvd = {hi, s1[31:0]};
    if (!sg) begin
      q   = dvd / {32'd0, d};
      sat = (q[63:32] != 0);
      return sat ? 64'h0000_0000_FFFF_FFFF : q;
    end
    neg = dvd[63] ^ d[31];
    am  = dvd[63] ? -dvd : dvd;
    bm  = d[31] ? -d : d;
    q   = am / {32'd0, bm};
    if (!neg) begin
      sat = (q > 64'h7FFF_FFFF);
      return sat ? 64'h0000_0000_7FFF_FFFF : q;
    end
    sat = (q > 64'h8000_0000);
    return sat ? 64'hFFFF_FFFF_8000_0000 : -q;
  endfunction

  task automatic run_op(input string req, input logic [31:0] hi, input logic [63:0] s1,
                        input logic [31:0] d, input bit sg, input bit cc, input bit poke);
    logic [63:0] exp;
    logic [3:0]  exp_icc;
    bit sat;
    int n;
    @(negedge clk);
    hi_word_i = hi; src1_i = s1; divisor_i = d; sgn_i = sg; cc_en_i = cc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (d == 32'd0) begin
      // R3: fault strobe, no busy, no done
      chk("R3 dz strobe", {61'd0, dz_fault_o, busy_o, done_o}, 64'd4);
      @(negedge clk);
      chk("R3 dz clear", {62'd0, dz_fault_o, done_o}, 64'd0);
      return;
    end
    n = 0;
    while (busy_o && n < 100) begin
      if (poke && n == 10) begin
        // R9: intruding request while busy
        hi_word_i = ~hi; src1_i = ~s1; divisor_i = 32'd3; sgn_i = ~sg; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    start_i = 1'b0;
    exp     = ref_div(hi, s1, d, sg, sat);
    exp_icc = cc ? {exp[31], (exp[31:0] == 32'd0), sat, 1'b0} : 4'b0000;
    chk("R8 busy cycles", 64'(n), 64'd64);
    chk("R8 done strobe", {63'd0, done_o}, 64'd1);
    chk(req, result_o, exp);
    chk("R7 flags", {60'd0, icc_o}, {60'd0, exp_icc});
    @(negedge clk);
    chk("R8 done one cycle", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; sgn_i = 1'b0; cc_en_i = 1'b0;
    hi_word_i = '0; src1_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk("R10 reset ctl", {61'd0, busy_o, done_o, dz_fault_o}, 64'd0);
    chk("R10 reset result", result_o, 64'd0);
    chk("R10 reset icc", {60'd0, icc_o}, 64'd0);

    run_op("R1 small", 32'd0, 64'hDEAD_0000_0000_0064, 32'd7, 1'b0, 1'b1, 1'b0);
    run_op("R1 high word", 32'd3, 64'h0, 32'd8, 1'b0, 1'b0, 1'b0);
    run_op("R4 unsigned clamp", 32'd5, 64'h1234, 32'd2, 1'b0, 1'b1, 1'b0);
    run_op("R4 unsigned edge", 32'd0, 64'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 1'b0);
    run_op("R2 neg/pos", 32'hFFFF_FFFF, 64'hFFFF_FFF9, 32'd2, 1'b1, 1'b1, 1'b0);
    run_op("R2 pos/neg", 32'd0, 64'd7, 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0);
    run_op("R2 neg/neg", 32'hFFFF_FFFF, 64'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0);
    run_op("R5 pos clamp", 32'd1, 64'd0, 32'd1, 1'b1, 1'b1, 1'b0);
    run_op("R5 exact max", 32'd0, 64'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, 1'b0);
    run_op("R5 min over minus one", 32'h8000_0000, 64'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
    run_op("R6 neg clamp", 32'hFFFF_FFFE, 64'd0, 32'd1, 1'b1, 1'b1, 1'b0);
    run_op("R6 exact min", 32'hFFFF_FFFF, 64'h8000_0000, 32'd1, 1'b1, 1'b1, 1'b0);
    run_op("R7 zero quotient", 32'd0, 64'd3, 32'd7, 1'b0, 1'b1, 1'b0);
    run_op("R7 cc off", 32'd9, 64'd0, 32'd1, 1'b1, 1'b0, 1'b0);
    run_op("R3", 32'd1, 64'd5, 32'd0, 1'b0, 1'b1, 1'b0);
    run_op("R3", 32'hFFFF_FFFF, 64'd5, 32'd0, 1'b1, 1'b1, 1'b0);
    run_op("R9 ignored start", 32'd2, 64'h55, 32'd1000, 1'b0, 1'b1, 1'b1);
    run_op("R9 ignored start signed", 32'hFFFF_FFF0, 64'h55, 32'd77, 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < 200; i++) begin
      logic [31:0] hi, d;
      logic [63:0] s1;
      bit sg, cc;
      sg = 1'($urandom % 2);
      cc = 1'($urandom % 2);
      s1 = {$urandom, $urandom};
      case ($urandom % 4)
        0: d = $urandom;
        1: d = ($urandom % 16) + 1;
        2: d = -(($urandom % 16) + 1);
        default: d = $urandom | 32'h0001_0000;
      endcase
      case ($urandom % 3)
        0: hi = $urandom;
        1: hi = $urandom % 4;
        default: hi = -($urandom % 4);
      endcase
      if (d == 32'd0) d = 32'd1;
      run_op(sg ? "R2 random signed" : "R1 random unsigned", hi, s1, d, sg, cc, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule